// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block holds the per-pin interrupt logic of a 32-pin general-purpose I/O port. Each pin has its own 4-bit trigger code, which selects rising edge, falling edge, both edges, high level or low level. A pin also has a detection-enable bit, which decides whether it may latch an event, and an unmask bit, which decides whether a latched event reaches an interrupt request. Software clears latched events by writing ones.

The unit uses the same simple register bus as the rest of the port: byte address, 32-bit write data, a single-cycle write strobe and combinational read data. Two request lines leave the block. One serves the lower half of the port and one serves the upper half. A handler services its line by reading the pending word and clearing one bit at a time until the word reads zero.

Pins are assumed to be synchronous to `clk`. The previous-level flop of each pin resets to 0. Bit 3 of a trigger code is stored and read back but does not change how detection works.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every register reads 0 and both request outputs are low.
- R2: Offset 0x14 is a read/write detection-enable word with one bit per pin. A pin whose bit is 0 never sets its raw bit.
- R3: Writing ones to offset 0x18 unmasks those pins, and writing ones to offset 0x1C masks them. Zero bits leave pins unchanged. Offset 0x1C reads back the unmask word, where 1 means unmasked.
- R4: Offset 0x20 reads the raw latched events whatever the mask says. Offset 0x24 reads raw AND unmask. An event whose condition is present at a clock edge is readable right after that edge.
- R5: Writing ones to offset 0x28 clears those raw bits from the next clock. Zero bits have no effect.
- R6: The trigger codes live in read/write words at 0x40, 0x44, 0x48 and 0x4C. Pin n uses word n/8, bits 4*(n mod 8)+3 down to 4*(n mod 8).
- R7: Trigger code bits [2:0] select the condition: 0 rising edge, 1 falling edge, 2 high level, 3 low level, 4 both edges. Values 5 to 7 never trigger. Bit 3 does not affect detection.
- R8: A level trigger sets the raw bit again on every clock while the level holds. A clear therefore only sticks once the pin is inactive.
- R9: When a clear write and a new event hit the same pin in the same clock, the raw bit stays set.
- R10: irq_lo_o is the OR of pending bits 15..0, and irq_hi_o is the OR of pending bits 31..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Pin levels, synchronous to clk |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_lo_o | output | 1 | Request for pins 15..0 |
| irq_hi_o | output | 1 | Request for pins 31..16 |

## Verification
The assertions rely on the bus decoder never raising the set-unmask and set-mask strobes in the same cycle. The address decode guarantees this, because the two strobes belong to different offsets. They also assume the pin levels are stable around each rising clock edge. The stimulus changes pins and the bus only at falling edges, so it stays within both assumptions. The stimulus mixes random pin toggles with random writes to every register, trigger codes 5 to 15 included. Directed sequences add a clear that collides with a fresh edge and a clear issued under a held level.

// File: rtl/gis_pkg.sv
// Shared constants for the GPIO interrupt sense unit.
// Assumes byte addressing with 32-bit registers.
package gis_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned MODE_W = 4;
    localparam int unsigned TRIG_W = 3;

    localparam int unsigned OFS_DETEN   = 32'h14;
    localparam int unsigned OFS_UNMASK  = 32'h18;
    localparam int unsigned OFS_MASK    = 32'h1C;
    localparam int unsigned OFS_RAW     = 32'h20;
    localparam int unsigned OFS_PEND    = 32'h24;
    localparam int unsigned OFS_CLR     = 32'h28;
    localparam int unsigned OFS_MODE0   = 32'h40;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_HIGH = 3'd2,
        TRIG_LOW  = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;
endpackage

// File: rtl/gis_pin_detect.sv
// Per-pin trigger detector: compares the current pin level with the level
// held from the previous clock and flags an event when the selected condition
// holds and detection is enabled. Assumes pin_i is synchronous to clk.
module gis_pin_detect
    import gis_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_i,
    input  logic              enable_i,
    input  logic [TRIG_W-1:0] trig_i,
    output logic              event_o
);
    logic pin_q;
    logic hit;

    // Hold the pin level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_i;
    end

    // Evaluate the selected trigger condition.
    always_comb begin
        case (trig_i)
            TRIG_RISE: hit = pin_i & ~pin_q;
            TRIG_FALL: hit = ~pin_i & pin_q;
            TRIG_HIGH: hit = pin_i;
            TRIG_LOW:  hit = ~pin_i;
            TRIG_BOTH: hit = pin_i ^ pin_q;
            default:   hit = 1'b0;
        endcase
    end

    assign event_o = enable_i & hit;
endmodule

// File: rtl/gis_cfg.sv
// Register decode and configuration storage: detection enables, trigger code
// words, and write-one strobes for unmask, mask and clear. Assumes one write
// per asserted bus_wr cycle; addresses outside the map are ignored.
module gis_cfg
    import gis_pkg::*;
#(
    parameter int unsigned NPINS      = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NMODE_REGS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [REG_W-1:0]                    wdata_i,
    output logic [NPINS-1:0]                    det_en_o,
    output logic [NPINS-1:0]                    unmask_set_o,
    output logic [NPINS-1:0]                    unmask_clr_o,
    output logic [NPINS-1:0]                    clr_o,
    output logic [NMODE_REGS-1:0][REG_W-1:0]    mode_o
);
    logic [NPINS-1:0] wbits;
    assign wbits = wdata_i[NPINS-1:0];

    // Write-one strobes, active only during their own write cycle.
    always_comb begin
        unmask_set_o = (wr_i && addr_i == ADDR_W'(OFS_UNMASK)) ? wbits : '0;
        unmask_clr_o = (wr_i && addr_i == ADDR_W'(OFS_MASK))   ? wbits : '0;
        clr_o        = (wr_i && addr_i == ADDR_W'(OFS_CLR))    ? wbits : '0;
    end

    // Detection-enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    det_en_o <= '0;
        else if (wr_i && addr_i == ADDR_W'(OFS_DETEN)) det_en_o <= wbits;
    end

    // One trigger-code word per group of pins.
    for (genvar k = 0; k < NMODE_REGS; k++) begin : g_mode
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_o[k] <= '0;
            else if (wr_i && addr_i == ADDR_W'(OFS_MODE0 + 4 * k))
                mode_o[k] <= wdata_i;
        end
    end
endmodule

// File: rtl/gis_status.sv
// Raw event latch and unmask state. A new event takes priority over a clear
// of the same bit; a set-unmask takes priority over a mask. Assumes the
// strobes come from gis_cfg and last one cycle.
module gis_status #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] event_i,
    input  logic [NPINS-1:0] clr_i,
    input  logic [NPINS-1:0] unmask_set_i,
    input  logic [NPINS-1:0] unmask_clr_i,
    output logic [NPINS-1:0] raw_o,
    output logic [NPINS-1:0] unmask_o,
    output logic [NPINS-1:0] pend_o
);
    // Latch events; clear only where no fresh event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= (raw_o & ~clr_i) | event_i;
    end

    // Track which pins may raise a request.
    always_ff @(posedge clk) begin
        if (!rst_n) unmask_o <= '0;
        else        unmask_o <= (unmask_o & ~unmask_clr_i) | unmask_set_i;
    end

    assign pend_o = raw_o & unmask_o;

    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~event_i) |=> ((raw_o & $past(clr_i & ~event_i)) == '0));
    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |event_i |=> ((raw_o & $past(event_i)) == $past(event_i)));
    // R3
    unmask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |unmask_set_i |=> ((unmask_o & $past(unmask_set_i)) == $past(unmask_set_i)));
    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |unmask_clr_i |=> ((unmask_o & $past(unmask_clr_i & ~unmask_set_i)) == '0));
endmodule

// File: rtl/gpio_irq_sense.sv
// Top of the GPIO interrupt sense unit: per-pin detectors, configuration,
// status latch, read multiplexer and the two half-port request lines.
// Assumes pins are synchronous to clk and NPINS is a multiple of 8, at most 32.
module gpio_irq_sense
    import gis_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    input  logic              bus_wr_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    output logic              irq_lo_o,
    output logic              irq_hi_o
);
    localparam int unsigned PINS_PER_REG = REG_W / MODE_W;
    localparam int unsigned NMODE_REGS   = (NPINS + PINS_PER_REG - 1) / PINS_PER_REG;
    localparam int unsigned HALF         = NPINS / 2;

    logic [NPINS-1:0]                 det_en, unmask_set, unmask_clr, clr;
    logic [NPINS-1:0]                 events, raw, unmask, pend;
    logic [NMODE_REGS-1:0][REG_W-1:0] mode_regs;

    gis_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .NMODE_REGS(NMODE_REGS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .det_en_o(det_en), .unmask_set_o(unmask_set),
        .unmask_clr_o(unmask_clr), .clr_o(clr), .mode_o(mode_regs)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        gis_pin_detect u_det (
            .clk(clk), .rst_n(rst_n), .pin_i(pins_i[n]), .enable_i(det_en[n]),
            .trig_i(mode_regs[n / PINS_PER_REG][(n % PINS_PER_REG) * MODE_W +: TRIG_W]),
            .event_o(events[n])
        );
    end

    gis_status #(.NPINS(NPINS)) u_status (
        .clk(clk), .rst_n(rst_n), .event_i(events), .clr_i(clr),
        .unmask_set_i(unmask_set), .unmask_clr_i(unmask_clr),
        .raw_o(raw), .unmask_o(unmask), .pend_o(pend)
    );

    // Return the register selected by the bus address.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFS_DETEN)) bus_rdata_o = REG_W'(det_en);
        if (bus_addr_i == ADDR_W'(OFS_MASK))  bus_rdata_o = REG_W'(unmask);
        if (bus_addr_i == ADDR_W'(OFS_RAW))   bus_rdata_o = REG_W'(raw);
        if (bus_addr_i == ADDR_W'(OFS_PEND))  bus_rdata_o = REG_W'(pend);
        for (int k = 0; k < NMODE_REGS; k++) begin
            if (bus_addr_i == ADDR_W'(OFS_MODE0 + 4 * k)) bus_rdata_o = mode_regs[k];
        end
    end

    assign irq_lo_o = |pend[HALF-1:0];
    assign irq_hi_o = |pend[NPINS-1:HALF];

    // R2
    rise_only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~$past(raw) & ~$past(det_en)) == '0));
endmodule

// File: tb/tb_gpio_irq_sense.sv
module tb_gpio_irq_sense;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pins;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wr;
    logic [31:0] rdata;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_en, m_um, m_raw, m_prev;
    logic [31:0] m_mode [4];

    always #2.5 clk = ~clk;

    gpio_irq_sense dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rdata_o(rdata),
        .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
    );

    function automatic logic hit_of(logic [3:0] code, logic p, logic q);
        case (code[2:0])
            3'd0:    return p & ~q;
            3'd1:    return ~p & q;
            3'd2:    return p;
            3'd3:    return ~p;
            3'd4:    return p ^ q;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #0.1;
        v = rdata;
    endtask

    // One clock cycle: drive pins and an optional write, update the model.
    task automatic cyc(logic [31:0] p, logic w, logic [7:0] a, logic [31:0] d);
        logic [31:0] evt, c;
        pins = p; wr = w; addr = a; wdata = d;
        for (int n = 0; n < 32; n++)
            evt[n] = m_en[n] & hit_of(m_mode[n/8][4*(n%8) +: 4], p[n], m_prev[n]);
        c = (w && a == 8'h28) ? d : 32'h0;
        m_raw = (m_raw & ~c) | evt;
        if (w) begin
            case (a)
                8'h14: m_en = d;
                8'h18: m_um = m_um | d;
                8'h1C: m_um = m_um & ~d;
                8'h40, 8'h44, 8'h48, 8'h4C: m_mode[(a - 8'h40) >> 2] = d;
                default: ;
            endcase
        end
        m_prev = p;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_all(string tag);
        logic [31:0] v, pd;
        pd = m_raw & m_um;
        rd(8'h14, v); chk("R2", {tag, " enable word"}, v, m_en);
        rd(8'h1C, v); chk("R3", {tag, " unmask word"}, v, m_um);
        rd(8'h20, v); chk("R4", {tag, " raw word"}, v, m_raw);
        rd(8'h24, v); chk("R4", {tag, " pending word"}, v, pd);
        for (int k = 0; k < 4; k++) begin
            rd(8'h40 + 8'(4*k), v); chk("R6", {tag, " mode word"}, v, m_mode[k]);
        end
        chk("R10", {tag, " request lines"}, {30'd0, irq_hi, irq_lo},
            {30'd0, |pd[31:16], |pd[15:0]});
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, p;
        void'($urandom(32'd20240607));
        rst_n = 1'b0; pins = '0; wr = 1'b0; addr = '0; wdata = '0;
        m_en = '0; m_um = '0; m_raw = '0; m_prev = '0;
        for (int k = 0; k < 4; k++) m_mode[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_all("R1 reset");
        chk("R1", "irq after reset", {30'd0, irq_hi, irq_lo}, 32'd0);

        // R3 set-unmask with zero bits leaving others alone
        cyc(32'h0, 1, 8'h14, 32'h0010_0008);
        cyc(32'h0, 1, 8'h18, 32'h0000_0008);
        rd(8'h1C, v); chk("R3", "unmask after first set", v, 32'h0000_0008);
        cyc(32'h0, 1, 8'h18, 32'h0010_0000);
        rd(8'h1C, v); chk("R3", "unmask after second set", v, 32'h0010_0008);
        // R6 pin 20 field sits in word 0x48 bits 19:16, code 2 = high level
        cyc(32'h0, 1, 8'h48, 32'h0002_0000);
        rd(8'h48, v); chk("R6", "mode word 2", v, 32'h0002_0000);

        // R4 rising edge on pin 3 latches and requests the low line
        cyc(32'h8, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R4", "raw after rise", v, 32'h8);
        chk("R10", "irq_lo after rise", {31'd0, irq_lo}, 32'd1);
        chk("R10", "irq_hi quiet", {31'd0, irq_hi}, 32'd0);
        // R5 clear while level stays high
        cyc(32'h8, 1, 8'h28, 32'h8);
        rd(8'h20, v); chk("R5", "raw after clear", v, 32'h0);
        chk("R10", "irq_lo after clear", {31'd0, irq_lo}, 32'd0);
        // R7 falling edge ignored by rising code
        cyc(32'h0, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R7", "raw after fall in rise mode", v, 32'h0);
        // R9 clear collides with a new rising edge
        cyc(32'h8, 1, 8'h28, 32'h8);
        rd(8'h20, v); chk("R9", "raw after collision", v, 32'h8);
        cyc(32'h8, 1, 8'h28, 32'h8);

        // R8 held high level on pin 20 survives a clear
        cyc(32'h0010_0008, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R8", "raw with level high", v, 32'h0010_0000);
        chk("R10", "irq_hi with level", {31'd0, irq_hi}, 32'd1);
        cyc(32'h0010_0008, 1, 8'h28, 32'h0010_0000);
        rd(8'h20, v); chk("R8", "raw after clear under level", v, 32'h0010_0000);
        cyc(32'h8, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R8", "raw latched after level ends", v, 32'h0010_0000);
        cyc(32'h8, 1, 8'h28, 32'h0010_0000);
        rd(8'h20, v); chk("R8", "raw after clear, level gone", v, 32'h0);
        chk("R10", "irq_hi after clear", {31'd0, irq_hi}, 32'd0);

        // R2 disabled pin 4 rises without latching
        cyc(32'h18, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R2", "raw for disabled pin", v, 32'h0);

        // R3 mask pin 3, event still raw but not pending
        cyc(32'h18, 1, 8'h1C, 32'h8);
        rd(8'h1C, v); chk("R3", "unmask after mask", v, 32'h0010_0000);
        cyc(32'h10, 0, 8'h0, 32'h0);
        cyc(32'h18, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R4", "raw while masked", v, 32'h8);
        rd(8'h24, v); chk("R4", "pending while masked", v, 32'h0);
        chk("R10", "irq_lo while masked", {31'd0, irq_lo}, 32'd0);

        // R7 pin 1 code 5 never fires, pin 2 code 0xC fires on both edges
        cyc(32'h18, 1, 8'h40, 32'h0000_0C50);
        cyc(32'h18, 1, 8'h14, 32'h0010_000E);
        cyc(32'h18, 1, 8'h28, 32'hFFFF_FFFF);
        cyc(32'h1E, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R7", "raw after rise on pins 1,2", v, 32'h4);
        cyc(32'h1E, 1, 8'h28, 32'hFFFF_FFFF);
        cyc(32'h18, 0, 8'h0, 32'h0);
        rd(8'h20, v); chk("R7", "raw after fall on pins 1,2", v, 32'h4);
        check_all("directed end");

        // Random phase
        p = 32'h18;
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [31:0] d;
            p = p ^ ($urandom & $urandom & $urandom);
            op = int'($urandom % 12);
            d = $urandom;
            case (op)
                0: cyc(p, 1, 8'h14, d);
                1: cyc(p, 1, 8'h18, d & $urandom);
                2: cyc(p, 1, 8'h1C, d & $urandom);
                3, 4: cyc(p, 1, 8'h28, d);
                5: cyc(p, 1, 8'h40 + 8'(4 * ($urandom % 4)), d);
                default: cyc(p, 0, 8'h0, 32'h0);
            endcase
            if (i % 4 == 3) check_all("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule